// File: doc/BRIEF.md
# Decode Operand Fetch with Result Bypass

This block is the operand side of the decode stage in a 32-bit, single-issue pipeline. In the decode cycle it takes the fetched instruction word, pulls out two source register indices and starts a read of both from a 32-entry register array. The array has one clock of read latency, and both reads are started every cycle whether the instruction needs them or not. One cycle later it presents the two operand values, a valid flag and the custom-instruction fields to the execute stage.

Results from single-cycle ALU operations reach the array through the shared write port. They also enter a short history of tagged results, and a matching history entry overrides the array value. A result committed at the same clock edge that ends the decode cycle is therefore already forwarded to the operands that follow. Loads and multi-cycle operations do not use the history. When such an instruction issues, a pending bit is set for its destination. While a decoded instruction uses a pending register, the block raises a stall so that decode holds the same word and decodes it again. When the long result is written back, its pending bit clears and any history entry with the same register number is discarded.

Top module: `opfwd_decode`

## Requirements
- R1: The first source index is `dec_insn[31:27]` and the second is `dec_insn[26:22]`. Operands for a word decoded in cycle t appear on `ex_opa`/`ex_opb` in cycle t+1. In that cycle `ex_valid` is 1 exactly when, in cycle t, `dec_valid` was 1, `dec_stall` was 0 and `flush` was 0.
- R2: A value written with `wr_en` at some clock edge is returned by every decode whose cycle ends at a later edge.
- R3: Register 0 always reads as zero. A write to it does not change the value read for register 0, and `iss_en` with `iss_rd` = 0 never causes a stall.
- R4: A single-cycle write (`wr_long` = 0) committed at the edge that ends the decode cycle is forwarded, so it reaches the operands in the following cycle.
- R5: When both history entries hold the same register, the newer value is forwarded.
- R6: After `iss_en` marks register r as pending, a valid decode whose used operand is r raises `dec_stall` in the same cycle, and `ex_valid` is 0 in the next cycle.
- R7: The first operand is checked for hazards on every primary opcode (`dec_insn[5:0]`) except 0x00 (absolute call) and 0x01 (absolute jump).
- R8: The second operand is used, and checked for hazards, only when `dec_insn[0]` differs from `dec_insn[1]`.
- R9: A long write (`wr_long` = 1) clears the pending bit of its register at the same edge as the array write. A stalled consumer stops stalling in the next cycle and receives the new value. An older history entry for that register is no longer forwarded.
- R10: For primary opcode 0x32, `ex_custom` is 1, `ex_xcode` carries `dec_insn[13:6]` and `ex_wb` carries `dec_insn[14]`. For any other opcode, `ex_custom` and `ex_wb` are 0.
- R11: `flush` clears every pending bit and the history, drops any `iss_en` in the same cycle, and suppresses `ex_valid` in the next cycle.
- R12: `dec_stall` is 0 whenever `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Clears history and pending bits; kills the decode slot |
| dec_valid | input | 1 | An instruction word is in decode |
| dec_insn | input | 32 | Instruction word in decode |
| dec_stall | output | 1 | Hold decode and decode the same word again |
| wr_en | input | 1 | Register write this cycle |
| wr_long | input | 1 | 1: load or multi-cycle result; 0: single-cycle ALU result |
| wr_rd | input | 5 | Destination register of the write |
| wr_data | input | DW | Write value |
| iss_en | input | 1 | A load or multi-cycle instruction has issued |
| iss_rd | input | 5 | Its destination register |
| ex_valid | output | 1 | Operands below are for a live instruction |
| ex_opa | output | DW | First operand |
| ex_opb | output | DW | Second operand |
| ex_custom | output | 1 | Decoded word was a custom instruction |
| ex_xcode | output | 8 | Extended custom code |
| ex_wb | output | 1 | Custom result is to be written back |

## Verification
A wrong history entry, whether stale, lost or in the wrong order, shows up one cycle after the affected decode as a wrong value on `ex_opa` or `ex_opb`. A history entry that survives a long write shows up as the old value right after a stall is released. A pending bit that is set in error shows up at once as `dec_stall` during the decode cycle, with `ex_valid` low in the cycle after. A pending bit that is lost shows up as a missing stall, followed by an operand value that is one write behind. Wrong use decoding shows as a stall that appears or is missing on the affected opcode patterns, in the same cycle as the decode.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  localparam int IW   = 32;
  localparam int RAW  = 5;
  localparam int NREG = 1 << RAW;

  localparam logic [5:0] OPC_CALL_ABS = 6'h00;
  localparam logic [5:0] OPC_JUMP_ABS = 6'h01;
  localparam logic [5:0] OPC_CUSTOM   = 6'h32;

  typedef struct packed {
    logic [RAW-1:0] src_a;
    logic [RAW-1:0] src_b;
    logic [5:0]     opc;
    logic [7:0]     xcode;
    logic           wb;
  } dfield_t;

  function automatic dfield_t split_insn(input logic [IW-1:0] w);
    dfield_t f;
    f.src_a = w[31:27];
    f.src_b = w[26:22];
    f.opc   = w[5:0];
    f.xcode = w[13:6];
    f.wb    = w[14];
    return f;
  endfunction

  function automatic logic reads_first(input logic [5:0] opc);
    return !(opc == OPC_CALL_ABS || opc == OPC_JUMP_ABS);
  endfunction

  function automatic logic reads_second(input logic [5:0] opc);
    return opc[0] ^ opc[1];
  endfunction
endpackage

// File: rtl/opfwd_regarray.sv
module opfwd_regarray #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // Both reads run every cycle; a read at the write edge returns the old word.
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata_a <= cells[raddr_a];
    rdata_b <= cells[raddr_b];
  end
endmodule

// File: rtl/opfwd_history.sv
module opfwd_history #(
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [AW-1:0] push_tag,
  input  logic [DW-1:0] push_data,
  input  logic          kill,
  input  logic [AW-1:0] kill_tag,
  input  logic [AW-1:0] look_a,
  input  logic [AW-1:0] look_b,
  output logic          hit_a,
  output logic          hit_b,
  output logic [DW-1:0] fwd_a,
  output logic [DW-1:0] fwd_b,
  output logic          head_vld,
  output logic [AW-1:0] head_tag,
  output logic [DW-1:0] head_data
);
  // Entry 0 is the newest; a push shifts every entry one step toward the tail.
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_live;
  logic [AW-1:0]    tag_q  [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_live
      assign vld_live[g] = vld_q[g] & ~(kill && (tag_q[g] == kill_tag));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) begin
      tag_q[0]  <= push_tag;
      data_q[0] <= push_data;
      for (int i = 1; i < DEPTH; i++) begin
        tag_q[i]  <= tag_q[i-1];
        data_q[i] <= data_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q <= '0;
    else if (flush) vld_q <= '0;
    else if (push)  vld_q <= {vld_live[DEPTH-2:0], 1'b1};
    else            vld_q <= vld_live;
  end

  // Scan from the tail up, so the newest match is the one kept.
  function automatic logic [DW:0] seek(input logic [AW-1:0] t);
    logic [DW:0] r;
    r = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i] && (tag_q[i] == t)) r = {1'b1, data_q[i]};
    end
    return r;
  endfunction

  always_comb begin
    {hit_a, fwd_a} = seek(look_a);
    {hit_b, fwd_b} = seek(look_b);
  end

  assign head_vld  = vld_q[0];
  assign head_tag  = tag_q[0];
  assign head_data = data_q[0];
endmodule

// File: rtl/opfwd_scoreboard.sv
module opfwd_scoreboard #(
  parameter int AW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 set_en,
  input  logic [AW-1:0]        set_idx,
  input  logic                 clr_en,
  input  logic [AW-1:0]        clr_idx,
  output logic [(1<<AW)-1:0]   pend
);
  localparam int N = 1 << AW;

  logic [N-1:0] pend_d;

  always_comb begin
    pend_d = pend;
    if (clr_en) pend_d[clr_idx] = 1'b0;
    if (set_en) pend_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend <= '0;
    else if (flush) pend <= '0;
    else            pend <= pend_d;
  end
endmodule

// File: rtl/opfwd_decode.sv
module opfwd_decode
  import opfwd_pkg::*;
#(
  parameter int DW     = 32,
  parameter int HDEPTH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           dec_valid,
  input  logic [IW-1:0]  dec_insn,
  output logic           dec_stall,
  input  logic           wr_en,
  input  logic           wr_long,
  input  logic [RAW-1:0] wr_rd,
  input  logic [DW-1:0]  wr_data,
  input  logic           iss_en,
  input  logic [RAW-1:0] iss_rd,
  output logic           ex_valid,
  output logic [DW-1:0]  ex_opa,
  output logic [DW-1:0]  ex_opb,
  output logic           ex_custom,
  output logic [7:0]     ex_xcode,
  output logic           ex_wb
);
  dfield_t f;
  logic    use_a, use_b, haz_a, haz_b;
  logic    wr_live, alu_push, long_done, iss_live;
  logic    unused_rsvd;

  logic [NREG-1:0] pend;
  logic [DW-1:0]   arr_a, arr_b, fwd_a, fwd_b;
  logic            hit_a, hit_b;
  logic            head_vld;
  logic [RAW-1:0]  head_tag;
  logic [DW-1:0]   head_data;

  logic [RAW-1:0]  ex_ra_q, ex_rb_q;

  assign f           = split_insn(dec_insn);
  assign unused_rsvd = ^dec_insn[21:15];

  assign use_a     = reads_first(f.opc);
  assign use_b     = reads_second(f.opc);
  assign haz_a     = use_a & pend[f.src_a];
  assign haz_b     = use_b & pend[f.src_b];
  assign dec_stall = dec_valid & (haz_a | haz_b);

  // Register 0 takes no write, no history entry and no pending bit.
  assign wr_live   = wr_en & (wr_rd != '0);
  assign alu_push  = wr_live & ~wr_long;
  assign long_done = wr_live & wr_long;
  assign iss_live  = iss_en & (iss_rd != '0);

  opfwd_regarray #(.DW(DW), .AW(RAW)) u_arr (
    .clk     (clk),
    .we      (wr_live),
    .waddr   (wr_rd),
    .wdata   (wr_data),
    .raddr_a (f.src_a),
    .raddr_b (f.src_b),
    .rdata_a (arr_a),
    .rdata_b (arr_b)
  );

  opfwd_history #(.DW(DW), .AW(RAW), .DEPTH(HDEPTH)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (alu_push),
    .push_tag  (wr_rd),
    .push_data (wr_data),
    .kill      (long_done),
    .kill_tag  (wr_rd),
    .look_a    (ex_ra_q),
    .look_b    (ex_rb_q),
    .hit_a     (hit_a),
    .hit_b     (hit_b),
    .fwd_a     (fwd_a),
    .fwd_b     (fwd_b),
    .head_vld  (head_vld),
    .head_tag  (head_tag),
    .head_data (head_data)
  );

  opfwd_scoreboard #(.AW(RAW)) u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .set_en  (iss_live),
    .set_idx (iss_rd),
    .clr_en  (long_done),
    .clr_idx (wr_rd),
    .pend    (pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_valid  <= 1'b0;
      ex_ra_q   <= '0;
      ex_rb_q   <= '0;
      ex_custom <= 1'b0;
      ex_xcode  <= '0;
      ex_wb     <= 1'b0;
    end else begin
      ex_valid  <= dec_valid & ~dec_stall & ~flush;
      ex_ra_q   <= f.src_a;
      ex_rb_q   <= f.src_b;
      ex_custom <= (f.opc == OPC_CUSTOM);
      ex_xcode  <= f.xcode;
      ex_wb     <= (f.opc == OPC_CUSTOM) & f.wb;
    end
  end

  assign ex_opa = (ex_ra_q == '0) ? '0 : (hit_a ? fwd_a : arr_a);
  assign ex_opb = (ex_rb_q == '0) ? '0 : (hit_b ? fwd_b : arr_b);
endmodule

module opfwd_decode_chk #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               dec_valid,
  input logic               dec_stall,
  input logic               ex_valid,
  input logic [DW-1:0]      ex_opa,
  input logic [AW-1:0]      ex_ra_q,
  input logic               wr_en,
  input logic               wr_long,
  input logic [AW-1:0]      wr_rd,
  input logic [DW-1:0]      wr_data,
  input logic               iss_en,
  input logic [AW-1:0]      iss_rd,
  input logic [(1<<AW)-1:0] pend,
  input logic               head_vld,
  input logic [AW-1:0]      head_tag,
  input logic [DW-1:0]      head_data
);
  a_r6_stall_kills_slot: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall |=> !ex_valid);

  a_r12_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_stall);

  a_r3_zero_reg_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ra_q == '0) |-> (ex_opa == '0));

  a_r4_push_lands_at_head: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_long && wr_rd != '0 && !flush)
      |=> (head_vld && head_tag == $past(wr_rd) && head_data == $past(wr_data)));

  a_r11_flush_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pend == '0));

  a_r9_done_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_long && !flush && !(iss_en && iss_rd == wr_rd))
      |=> !pend[$past(wr_rd)]);
endmodule

bind opfwd_decode opfwd_decode_chk #(.DW(DW), .AW(opfwd_pkg::RAW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .dec_valid (dec_valid),
  .dec_stall (dec_stall),
  .ex_valid  (ex_valid),
  .ex_opa    (ex_opa),
  .ex_ra_q   (ex_ra_q),
  .wr_en     (wr_en),
  .wr_long   (wr_long),
  .wr_rd     (wr_rd),
  .wr_data   (wr_data),
  .iss_en    (iss_en),
  .iss_rd    (iss_rd),
  .pend      (pend),
  .head_vld  (head_vld),
  .head_tag  (head_tag),
  .head_data (head_data)
);

// File: tb/opfwd_decode_tb.sv
`timescale 1ns/1ps
module opfwd_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        dec_valid = 1'b0;
  logic [31:0] dec_insn = '0;
  logic        dec_stall;
  logic        wr_en = 1'b0, wr_long = 1'b0;
  logic [4:0]  wr_rd = '0;
  logic [31:0] wr_data = '0;
  logic        iss_en = 1'b0;
  logic [4:0]  iss_rd = '0;
  logic        ex_valid, ex_custom, ex_wb;
  logic [31:0] ex_opa, ex_opb;
  logic [7:0]  ex_xcode;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  opfwd_decode dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .dec_valid(dec_valid), .dec_insn(dec_insn), .dec_stall(dec_stall),
    .wr_en(wr_en), .wr_long(wr_long), .wr_rd(wr_rd), .wr_data(wr_data),
    .iss_en(iss_en), .iss_rd(iss_rd),
    .ex_valid(ex_valid), .ex_opa(ex_opa), .ex_opb(ex_opb),
    .ex_custom(ex_custom), .ex_xcode(ex_xcode), .ex_wb(ex_wb)
  );

  typedef struct packed {
    logic        wv; logic wl; logic [4:0] wr; logic [31:0] wd;
    logic        iv; logic [4:0] ir;
    logic        dv; logic [4:0] ra; logic [4:0] rb; logic [5:0] op;
    logic        es;
    logic        ca; logic [31:0] ea;
    logic        cb; logic [31:0] eb;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1,1,5'd3,32'h1111_0003, 0,5'd0, 0,5'd0,5'd0,6'h00, 0, 0,32'h0, 0,32'h0, 4'd2},          // R2 preload
    '{1,1,5'd4,32'h2222_0004, 0,5'd0, 0,5'd0,5'd0,6'h00, 0, 0,32'h0, 0,32'h0, 4'd2},          // R2 preload
    '{0,0,5'd0,32'h0,         0,5'd0, 1,5'd3,5'd4,6'h05, 0, 1,32'h1111_0003, 1,32'h2222_0004, 4'd1}, // R1 R2
    '{1,0,5'd0,32'hDEAD_BEEF, 0,5'd0, 1,5'd0,5'd3,6'h05, 0, 1,32'h0, 1,32'h1111_0003, 4'd3},  // R3
    '{1,0,5'd7,32'h0000_00A7, 0,5'd0, 1,5'd7,5'd3,6'h05, 0, 1,32'h0000_00A7, 1,32'h1111_0003, 4'd4}, // R4
    '{1,0,5'd7,32'h0000_00B7, 0,5'd0, 1,5'd7,5'd7,6'h05, 0, 1,32'h0000_00B7, 1,32'h0000_00B7, 4'd5}, // R5
    '{0,0,5'd0,32'h0,         0,5'd0, 1,5'd7,5'd3,6'h05, 0, 1,32'h0000_00B7, 1,32'h1111_0003, 4'd5}, // R5
    '{0,0,5'd0,32'h0,         1,5'd9, 0,5'd9,5'd9,6'h05, 0, 0,32'h0, 0,32'h0, 4'd12},         // R12
    '{0,0,5'd0,32'h0,         0,5'd0, 1,5'd9,5'd3,6'h05, 1, 0,32'h0, 0,32'h0, 4'd6},          // R6
    '{0,0,5'd0,32'h0,         0,5'd0, 1,5'd3,5'd9,6'h05, 1, 0,32'h0, 0,32'h0, 4'd8},          // R8 used
    '{0,0,5'd0,32'h0,         0,5'd0, 1,5'd3,5'd9,6'h04, 0, 1,32'h1111_0003, 0,32'h0, 4'd8},  // R8 unused
    '{0,0,5'd0,32'h0,         0,5'd0, 1,5'd9,5'd3,6'h00, 0, 0,32'h0, 1,32'h1111_0003, 4'd7},  // R7 call
    '{0,0,5'd0,32'h0,         0,5'd0, 1,5'd9,5'd0,6'h01, 0, 0,32'h0, 1,32'h0, 4'd7},          // R7 jump
    '{1,1,5'd9,32'h9999_0009, 0,5'd0, 1,5'd9,5'd3,6'h05, 1, 0,32'h0, 0,32'h0, 4'd9},          // R9 same-edge
    '{0,0,5'd0,32'h0,         0,5'd0, 1,5'd9,5'd3,6'h05, 0, 1,32'h9999_0009, 1,32'h1111_0003, 4'd9}, // R9 restart
    '{1,0,5'd12,32'h0000_00C0,0,5'd0, 0,5'd0,5'd0,6'h00, 0, 0,32'h0, 0,32'h0, 4'd9},
    '{0,0,5'd0,32'h0,         1,5'd12,0,5'd0,5'd0,6'h00, 0, 0,32'h0, 0,32'h0, 4'd9},
    '{1,1,5'd12,32'h0000_00C1,0,5'd0, 0,5'd0,5'd0,6'h00, 0, 0,32'h0, 0,32'h0, 4'd9},
    '{0,0,5'd0,32'h0,         0,5'd0, 1,5'd12,5'd7,6'h05, 0, 1,32'h0000_00C1, 1,32'h0000_00B7, 4'd9}, // R9 stale entry
    '{0,0,5'd0,32'h0,         1,5'd0, 0,5'd0,5'd0,6'h00, 0, 0,32'h0, 0,32'h0, 4'd3},          // R3 issue r0
    '{0,0,5'd0,32'h0,         0,5'd0, 1,5'd0,5'd0,6'h05, 0, 1,32'h0, 1,32'h0, 4'd3}           // R3
  };

  function automatic logic [31:0] mkinsn(input logic [4:0] a, input logic [4:0] b,
                                         input logic [5:0] op, input logic [7:0] xc,
                                         input logic wb);
    return {a, b, 7'b0, wb, xc, op};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_long = 0; wr_rd = 0; wr_data = 0;
    iss_en = 0; iss_rd = 0; dec_valid = 0; dec_insn = 0; flush = 0;
  endtask

  task automatic drive(input vec_t v);
    wr_en = v.wv; wr_long = v.wl; wr_rd = v.wr; wr_data = v.wd;
    iss_en = v.iv; iss_rd = v.ir;
    dec_valid = v.dv; dec_insn = mkinsn(v.ra, v.rb, v.op, 8'h00, 1'b0);
  endtask

  task automatic check_ex(input vec_t v);
    string t;
    t = $sformatf("R%0d", v.req);
    chk({t, " ex_valid"}, {31'b0, ex_valid}, {31'b0, v.dv & ~v.es});
    if (v.dv && !v.es && v.ca) chk({t, " ex_opa"}, ex_opa, v.ea);
    if (v.dv && !v.es && v.cb) chk({t, " ex_opb"}, ex_opb, v.eb);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1 R12: reset state
    chk("R1 reset ex_valid", {31'b0, ex_valid}, 32'd0);
    chk("R12 reset dec_stall", {31'b0, dec_stall}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) check_ex(VECS[i-1]);
      drive(VECS[i]);
      #1;
      chk($sformatf("R%0d dec_stall vec%0d", VECS[i].req, i), {31'b0, dec_stall}, {31'b0, VECS[i].es});
    end
    @(negedge clk);
    check_ex(VECS[NV-1]);
    idle();

    // R10: custom fields
    dec_valid = 1; dec_insn = mkinsn(5'd3, 5'd4, 6'h32, 8'hA5, 1'b1);
    @(negedge clk);
    chk("R10 custom flag", {31'b0, ex_custom}, 32'd1);
    chk("R10 xcode", {24'b0, ex_xcode}, 32'h0000_00A5);
    chk("R10 wb set", {31'b0, ex_wb}, 32'd1);
    dec_insn = mkinsn(5'd3, 5'd4, 6'h32, 8'h3C, 1'b0);
    @(negedge clk);
    chk("R10 xcode2", {24'b0, ex_xcode}, 32'h0000_003C);
    chk("R10 wb clear", {31'b0, ex_wb}, 32'd0);
    dec_insn = mkinsn(5'd3, 5'd4, 6'h05, 8'hFF, 1'b1);
    @(negedge clk);
    chk("R10 not custom", {31'b0, ex_custom}, 32'd0);
    chk("R10 no wb", {31'b0, ex_wb}, 32'd0);
    idle();

    // R11: flush clears pending bits and drops a same-cycle issue
    iss_en = 1; iss_rd = 5'd20;
    @(negedge clk);
    idle();
    dec_valid = 1; dec_insn = mkinsn(5'd20, 5'd0, 6'h04, 8'h00, 1'b0);
    #1;
    chk("R6 stall before flush", {31'b0, dec_stall}, 32'd1);
    @(negedge clk);
    dec_insn = mkinsn(5'd3, 5'd0, 6'h04, 8'h00, 1'b0);
    flush = 1; iss_en = 1; iss_rd = 5'd21;
    @(negedge clk);
    chk("R11 flushed slot", {31'b0, ex_valid}, 32'd0);
    idle();
    dec_valid = 1; dec_insn = mkinsn(5'd20, 5'd21, 6'h05, 8'h00, 1'b0);
    #1;
    chk("R11 no stall after flush", {31'b0, dec_stall}, 32'd0);
    @(negedge clk);
    chk("R11 slot live after flush", {31'b0, ex_valid}, 32'd1);
    idle();
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule